// File: doc/BRIEF.md
# Translation Table Region Selector

This block decides which of two translation-table bases should serve a 64-bit input address: the low region (region 0, addresses whose upper bits are all zero) or the high region (region 1, addresses whose upper bits are all one). Each region is described by a size field (`tsz`, the number of upper address bits that must be uniform), a top-byte-ignore enable, a disable bit and a granule size. The selector either names a region and forwards that region's granule and size, or raises a translation fault.

A request is presented with `req_valid` together with the address and configuration. The decision is made combinationally and captured in one register stage, so `rsp_valid` and the result appear one clock later. A region whose size field is zero is treated as unconfigured and takes every address the other region does not claim. The page-table walk that follows the selection lives elsewhere.

Top module: `tt_region_select`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. Result fields are updated only on a request and hold their value otherwise.
- R2: Address bit 55 picks the top-byte-ignore enable that applies: bit 55 = 1 uses `tbi_hi`, bit 55 = 0 uses `tbi_lo`, regardless of which region is finally selected.
- R3: The low region (`rsp_region` = 0) is selected when `tsz_lo` is nonzero and every checked address bit is 0. This test is made before all others.
- R4: The high region (`rsp_region` = 1) is selected when the low test fails, `tsz_hi` is nonzero and every checked address bit is 1.
- R5: When both region tests fail and `tsz_lo` is zero, the low region is selected.
- R6: When both region tests fail, `tsz_lo` is nonzero and `tsz_hi` is zero, the high region is selected.
- R7: When both size fields are nonzero and neither region test passes, `rsp_fault` = 1 with `rsp_region`, `rsp_gran` and `rsp_tsz` all 0.
- R8: When the selected region has its disable bit set, `rsp_fault` = 1 while `rsp_region`, `rsp_gran` and `rsp_tsz` still report that region.
- R9: For a region with size field `tsz`, the checked bits are [63 - 8*t : 64 - tsz], where t is the applicable top-byte-ignore enable; bits outside that range never affect the result. If the range is empty (t = 1 and `tsz` <= 8) the region test passes.
- R10: While reset is held and in the first cycle after it, `rsp_valid`, `rsp_fault`, `rsp_region`, `rsp_gran` and `rsp_tsz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Input address |
| tsz_lo | input | 6 | Size field of the low region (0 = unconfigured) |
| tsz_hi | input | 6 | Size field of the high region (0 = unconfigured) |
| tbi_lo | input | 1 | Top-byte-ignore enable used when address bit 55 is 0 |
| tbi_hi | input | 1 | Top-byte-ignore enable used when address bit 55 is 1 |
| dis_lo | input | 1 | Low region disabled |
| dis_hi | input | 1 | High region disabled |
| gran_lo | input | 5 | Granule size (log2 bytes) of the low region |
| gran_hi | input | 5 | Granule size (log2 bytes) of the high region |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_region | output | 1 | Selected region: 0 low, 1 high |
| rsp_gran | output | 5 | Granule size of the selected region |
| rsp_tsz | output | 6 | Size field of the selected region |
| rsp_fault | output | 1 | Translation fault |

## Verification
The bench targets the address just above a configured low region, where a selector that checked the wrong bit range would hand the address to the low table instead of faulting. It flips only the top-byte-ignore enables around an address whose top byte is non-zero, so a design that keyed the enable off the wrong bit, or ignored it, reports a fault where a region is due or the other way round. Unconfigured-region fallbacks and a disabled fallback region are each driven, catching a wrong check order that would fault or pick the other base, and the empty checked field (size 8 with top-byte-ignore) catches an unsigned underflow in the bound arithmetic.

// File: rtl/tt_sel_pkg.sv
// Package: shared encodings for the translation-table region selector.
// Assumes: exactly two regions, low (0) and high (1).
package tt_sel_pkg;
    typedef enum logic {
        REGION_LOW  = 1'b0,
        REGION_HIGH = 1'b1
    } region_e;
endpackage

// File: rtl/tt_field_mask.sv
// Module: tt_field_mask
// Builds the mask of address bits inspected by a region test.
// Bits [ADDR_W-1-IGN_BITS*tbi : ADDR_W-tsz] are set; a zero tsz gives an
// empty mask. Assumes tsz < 2**TSZ_W <= ADDR_W.
module tt_field_mask #(
    parameter int ADDR_W   = 64,
    parameter int TSZ_W    = 6,
    parameter int IGN_BITS = 8
) (
    input  logic [TSZ_W-1:0]  tsz,
    input  logic              tbi,
    output logic [ADDR_W-1:0] mask
);
    localparam int BW = 32;

    logic [BW-1:0] lo_bound;
    logic [BW-1:0] hi_bound;

    // Bounds of the inspected field, inclusive.
    always_comb begin
        lo_bound = BW'(ADDR_W) - BW'(tsz);
        hi_bound = BW'(ADDR_W - 1) - (tbi ? BW'(IGN_BITS) : '0);
    end

    // One comparator pair per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign mask[i] = (tsz != '0) && (BW'(i) >= lo_bound) && (BW'(i) <= hi_bound);
    end
endmodule

// File: rtl/tt_region_cmp.sv
// Module: tt_region_cmp
// Tests whether an address lies in one region: all inspected bits zero for
// the low region (WANT_ONES=0) or all one for the high region (WANT_ONES=1).
// An unconfigured region (tsz = 0) never passes. Empty field passes.
module tt_region_cmp #(
    parameter int ADDR_W    = 64,
    parameter int TSZ_W     = 6,
    parameter int IGN_BITS  = 8,
    parameter bit WANT_ONES = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TSZ_W-1:0]  tsz,
    input  logic              tbi,
    output logic              hit
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] picked;
    logic              uniform;

    tt_field_mask #(
        .ADDR_W  (ADDR_W),
        .TSZ_W   (TSZ_W),
        .IGN_BITS(IGN_BITS)
    ) u_mask (
        .tsz (tsz),
        .tbi (tbi),
        .mask(mask)
    );

    // Keep only the inspected bits.
    assign picked = addr & mask;

    // Polarity of the uniformity test is a build-time choice.
    if (WANT_ONES) begin : g_ones
        assign uniform = (picked == mask);
    end else begin : g_zeros
        assign uniform = (picked == '0);
    end

    // Region passes only if configured.
    assign hit = (tsz != '0) && uniform;
endmodule

// File: rtl/tt_select_core.sv
// Module: tt_select_core
// Priority decision: low hit, high hit, low unconfigured, high unconfigured,
// else gap fault. A disabled chosen region also faults. Purely combinational.
module tt_select_core
    import tt_sel_pkg::*;
#(
    parameter int TSZ_W  = 6,
    parameter int GRAN_W = 5
) (
    input  logic              lo_hit,
    input  logic              hi_hit,
    input  logic [TSZ_W-1:0]  tsz_lo,
    input  logic [TSZ_W-1:0]  tsz_hi,
    input  logic              dis_lo,
    input  logic              dis_hi,
    input  logic [GRAN_W-1:0] gran_lo,
    input  logic [GRAN_W-1:0] gran_hi,
    output region_e           sel,
    output logic              fault,
    output logic [TSZ_W-1:0]  sel_tsz,
    output logic [GRAN_W-1:0] sel_gran
);
    logic gap;

    // Ordered region choice.
    always_comb begin
        gap = 1'b0;
        sel = REGION_LOW;
        if (lo_hit)               sel = REGION_LOW;
        else if (hi_hit)          sel = REGION_HIGH;
        else if (tsz_lo == '0)    sel = REGION_LOW;
        else if (tsz_hi == '0)    sel = REGION_HIGH;
        else                      gap = 1'b1;
    end

    // Attribute forwarding and fault composition.
    always_comb begin
        if (gap) begin
            sel_tsz  = '0;
            sel_gran = '0;
            fault    = 1'b1;
        end else if (sel == REGION_HIGH) begin
            sel_tsz  = tsz_hi;
            sel_gran = gran_hi;
            fault    = dis_hi;
        end else begin
            sel_tsz  = tsz_lo;
            sel_gran = gran_lo;
            fault    = dis_lo;
        end
    end

    // R3: a low hit can never produce the high region.
    always_comb begin
        a_r3_low_first: assert (!(lo_hit && sel == REGION_HIGH));
    end
endmodule

// File: rtl/tt_region_select.sv
// Module: tt_region_select (top)
// Chooses the translation-table region for an address, or faults, and
// registers the result once: response appears the cycle after req_valid.
// Assumes synchronous active-low reset; inputs are stable in a request cycle.
module tt_region_select
    import tt_sel_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int TSZ_W    = 6,
    parameter int GRAN_W   = 5,
    parameter int IGN_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TSZ_W-1:0]  tsz_lo,
    input  logic [TSZ_W-1:0]  tsz_hi,
    input  logic              tbi_lo,
    input  logic              tbi_hi,
    input  logic              dis_lo,
    input  logic              dis_hi,
    input  logic [GRAN_W-1:0] gran_lo,
    input  logic [GRAN_W-1:0] gran_hi,
    output logic              rsp_valid,
    output logic              rsp_region,
    output logic [GRAN_W-1:0] rsp_gran,
    output logic [TSZ_W-1:0]  rsp_tsz,
    output logic              rsp_fault
);
    localparam int SEL_BIT = ADDR_W - IGN_BITS - 1;
    localparam int NREG    = 2;

    logic              tbi_eff;
    logic [NREG-1:0]   hit;
    logic [TSZ_W-1:0]  tsz_v [NREG];
    region_e           sel;
    logic              fault_c;
    logic [TSZ_W-1:0]  tsz_c;
    logic [GRAN_W-1:0] gran_c;

    // Address bit just below the ignorable byte picks the enable.
    assign tbi_eff  = req_addr[SEL_BIT] ? tbi_hi : tbi_lo;
    assign tsz_v[0] = tsz_lo;
    assign tsz_v[1] = tsz_hi;

    // One region test per region; region index sets the polarity.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        tt_region_cmp #(
            .ADDR_W   (ADDR_W),
            .TSZ_W    (TSZ_W),
            .IGN_BITS (IGN_BITS),
            .WANT_ONES(r == 1)
        ) u_cmp (
            .addr(req_addr),
            .tsz (tsz_v[r]),
            .tbi (tbi_eff),
            .hit (hit[r])
        );
    end

    tt_select_core #(
        .TSZ_W (TSZ_W),
        .GRAN_W(GRAN_W)
    ) u_core (
        .lo_hit  (hit[0]),
        .hi_hit  (hit[1]),
        .tsz_lo  (tsz_lo),
        .tsz_hi  (tsz_hi),
        .dis_lo  (dis_lo),
        .dis_hi  (dis_hi),
        .gran_lo (gran_lo),
        .gran_hi (gran_hi),
        .sel     (sel),
        .fault   (fault_c),
        .sel_tsz (tsz_c),
        .sel_gran(gran_c)
    );

    // Valid strobe: one cycle delay of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Result register: loads on a request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_region <= 1'b0;
            rsp_gran   <= '0;
            rsp_tsz    <= '0;
            rsp_fault  <= 1'b0;
        end else if (req_valid) begin
            rsp_region <= sel;
            rsp_gran   <= gran_c;
            rsp_tsz    <= tsz_c;
            rsp_fault  <= fault_c;
        end
    end

    // R1: response follows a request by one cycle.
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1: no response without a request.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R1: result fields hold between requests.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_fault) && $stable(rsp_region));
    // R7: both configured and neither matches gives a fault.
    a_r7_gap_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tsz_lo != '0 && tsz_hi != '0 && !hit[0] && !hit[1])
        |=> (rsp_fault && !rsp_region));
    // R8: a low match on a disabled low region faults.
    a_r8_disabled_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit[0] && dis_lo) |=> (rsp_fault && !rsp_region));
    // R3: a clean low match is reported as the low region without fault.
    a_r3_low_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit[0] && !dis_lo) |=> (!rsp_fault && !rsp_region));
endmodule

// File: tb/tt_region_select_tb_top.sv
module tt_region_select_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [5:0]  tsz_lo = '0, tsz_hi = '0;
    logic        tbi_lo = 1'b0, tbi_hi = 1'b0, dis_lo = 1'b0, dis_hi = 1'b0;
    logic [4:0]  gran_lo = 5'd12, gran_hi = 5'd16;
    logic        rsp_valid, rsp_region, rsp_fault;
    logic [4:0]  rsp_gran;
    logic [5:0]  rsp_tsz;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tt_region_select dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .tsz_lo(tsz_lo), .tsz_hi(tsz_hi), .tbi_lo(tbi_lo), .tbi_hi(tbi_hi),
        .dis_lo(dis_lo), .dis_hi(dis_hi), .gran_lo(gran_lo), .gran_hi(gran_hi),
        .rsp_valid(rsp_valid), .rsp_region(rsp_region), .rsp_gran(rsp_gran),
        .rsp_tsz(rsp_tsz), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; results are sampled at the next one.
    task automatic send(input logic [63:0] a);
        @(negedge clk);
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Send and compare all result fields.
    task automatic expect_result(input string req, input logic [63:0] a,
                                 input logic reg_e, input logic flt_e);
        logic [5:0] t_e;
        logic [4:0] g_e;
        send(a);
        if (flt_e && !dis_lo && !dis_hi) begin t_e = '0; g_e = '0; end
        else if (reg_e) begin t_e = tsz_hi; g_e = gran_hi; end
        else begin t_e = tsz_lo; g_e = gran_lo; end
        check({req, " valid"},  32'(rsp_valid), 32'd1);
        check({req, " region"}, 32'(rsp_region), 32'(reg_e));
        check({req, " fault"},  32'(rsp_fault), 32'(flt_e));
        check({req, " tsz"},    32'(rsp_tsz), 32'(t_e));
        check({req, " gran"},   32'(rsp_gran), 32'(g_e));
    endtask

    task automatic t_reset;
        check("R10 valid", 32'(rsp_valid), 32'd0);
        check("R10 fault", 32'(rsp_fault), 32'd0);
        check("R10 region", 32'(rsp_region), 32'd0);
        check("R10 tsz", 32'(rsp_tsz), 32'd0);
    endtask

    task automatic t_regions;
        tsz_lo = 6'd16; tsz_hi = 6'd16;
        expect_result("R3 low",  64'h0000_1234_5678_9000, 1'b0, 1'b0);
        expect_result("R4 high", 64'hFFFF_8000_0000_0000, 1'b1, 1'b0);
        expect_result("R7 gap",  64'h0001_0000_0000_0000, 1'b0, 1'b1);
        expect_result("R7 gap top", 64'h8000_0000_0000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_tbi;
        tsz_lo = 6'd16; tsz_hi = 6'd16;
        tbi_lo = 1'b1; tbi_hi = 1'b0;
        expect_result("R2 tbi_lo applies", 64'h5A00_0000_0000_1000, 1'b0, 1'b0);
        tbi_lo = 1'b0; tbi_hi = 1'b1;
        expect_result("R2 tbi_hi ignored on bit55=0", 64'h5A00_0000_0000_1000, 1'b0, 1'b1);
        expect_result("R2 tbi_hi on bit55=1", 64'h12FF_F000_0000_0000, 1'b1, 1'b0);
        tbi_hi = 1'b0;
        expect_result("R9 top byte checked", 64'h12FF_F000_0000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_fallback;
        tsz_lo = 6'd0; tsz_hi = 6'd16;
        expect_result("R5 low fallback", 64'h0001_0000_0000_0000, 1'b0, 1'b0);
        expect_result("R4 high before fallback", 64'hFFFF_0000_0000_0000, 1'b1, 1'b0);
        tsz_lo = 6'd16; tsz_hi = 6'd0;
        expect_result("R6 high fallback", 64'h8000_0000_0000_0000, 1'b1, 1'b0);
        expect_result("R3 low before fallback", 64'h0000_FFFF_0000_0000, 1'b0, 1'b0);
        tsz_lo = 6'd0; tsz_hi = 6'd0;
        expect_result("R5 both unconfigured", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_disable;
        tsz_lo = 6'd16; tsz_hi = 6'd16; dis_lo = 1'b1;
        expect_result("R8 low disabled", 64'h0000_0000_0000_4000, 1'b0, 1'b1);
        dis_lo = 1'b0; dis_hi = 1'b1; tsz_hi = 6'd0;
        expect_result("R8 high fallback disabled", 64'h4000_0000_0000_0000, 1'b1, 1'b1);
        dis_hi = 1'b0;
    endtask

    task automatic t_field;
        tsz_lo = 6'd8; tsz_hi = 6'd8;
        expect_result("R9 lower bits ignored", 64'h00FF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        tbi_lo = 1'b1;
        expect_result("R9 empty field", 64'h7F00_0000_0000_0000, 1'b0, 1'b0);
        tbi_lo = 1'b0;
    endtask

    task automatic t_timing;
        tsz_lo = 6'd16; tsz_hi = 6'd16;
        @(negedge clk);
        req_addr = 64'hFFFF_0000_0000_0000; req_valid = 1'b1;
        @(negedge clk);
        check("R1 first of pair", 32'(rsp_region), 32'd1);
        req_addr = 64'h0000_0000_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 second of pair", 32'(rsp_region), 32'd0);
        req_addr = 64'hFFFF_0000_0000_0000;
        @(negedge clk);
        check("R1 idle no valid", 32'(rsp_valid), 32'd0);
        check("R1 idle hold", 32'(rsp_region), 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regions();
        t_tbi();
        t_fallback();
        t_disable();
        t_field();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule